// File: doc/BRIEF.md
# Mode Command Discrete I/O Bridge

This block belongs to the command path of a MIL-STD-1553 remote terminal. A decoder ahead of it presents a command that has already been checked, as a set of fields with a one-cycle valid strobe, a legality flag, the received data word and two per-command configuration bits. The bridge turns such a command into activity on a small discrete I/O bus. Every legal command is first announced: a command strobe and the active-low write strobe pulse together, and the 5-bit discrete output carries either the command's word count/mode code field or a one-hot pulse chosen by a select value that comes from the command's tag word.

When direct I/O is enabled, four reserved mode codes also move one byte over the I/O bus in the cycle after the announcement. Transmit codes 24 and 25 read a byte and return it as the low byte of the transmit data word. Receive codes 27 and 28 write the low byte of the received data word. These transfers need nothing from the host, so they work while the host is uninitialized or busy. Commands reach the block at least two cycles apart.

Top module: `mcio_bridge`

## Requirements
- R1: While reset is low and after it is released, outputs are idle: io_cmds 0, io_wr_n 1, io_rd_n 1, io_addr 0, io_wdata 0, dsc_out 0, tx_word 0.
- R2: A cmd_vld with cmd_legal 1 raises io_cmds and drives io_wr_n low for exactly the next cycle. A cmd_vld with cmd_legal 0 causes no output activity at all.
- R3: With cfg_echo 1 at cmd_vld, dsc_out equals cmd_field during the announce cycle.
- R4: With cfg_echo 0 at cmd_vld, dsc_out during the announce cycle has only bit tag_pulse_sel set when tag_pulse_sel is 0 to 4, and is all zeros when it is 5 to 7.
- R5: Outside the announce cycle, dsc_out is zero.
- R6: With cfg_dio_en 1, cmd_mode 1 and cmd_legal 1, the cycle two after cmd_vld is a single transfer cycle with io_cmds 0. Transmit (cmd_tx 1) code 24 reads address 0 and code 25 reads address 2: io_rd_n 0, io_wr_n 1. Receive (cmd_tx 0) code 27 writes address 2 and code 28 writes address 0: io_wr_n 0, io_rd_n 1.
- R7: During a write transfer io_wdata equals rx_word[7:0]; bits 15:8 of rx_word have no effect. At all other times io_wdata is 0.
- R8: A read transfer samples io_rdata at the end of its cycle. From the next cycle on, tx_word is {8'h00, that byte}, and it holds until the next read.
- R9: No transfer happens when cfg_dio_en is 0, when cmd_mode is 0, when the direction does not match the code, or for any other code. The announce still happens.
- R10: A command whose cmd_vld falls in the transfer cycle of the previous command changes neither that transfer's address, strobes or write data nor the byte it captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_vld | input | 1 | One-cycle strobe for a decoded command |
| cmd_legal | input | 1 | Command is valid and legal |
| cmd_tx | input | 1 | 1 = transmit command, 0 = receive command |
| cmd_mode | input | 1 | Subaddress marks a mode command |
| cmd_field | input | 5 | Word count / mode code field |
| rx_word | input | 16 | Received data word |
| cfg_dio_en | input | 1 | Enables the direct-I/O mode codes |
| cfg_echo | input | 1 | 1 = echo field on dsc_out, 0 = one-hot pulse |
| tag_pulse_sel | input | 3 | Pulse select value from the tag word |
| io_rdata | input | 8 | Byte returned by the I/O bus on a read |
| io_addr | output | 2 | I/O address |
| io_wr_n | output | 1 | Active-low I/O write strobe |
| io_rd_n | output | 1 | Active-low I/O read strobe |
| io_cmds | output | 1 | Command announce strobe |
| io_wdata | output | 8 | I/O write byte |
| dsc_out | output | 5 | Discrete output: pulse or echoed field |
| tx_word | output | 16 | Data word returned for transmit codes |

## Verification
Two things can fall in the same cycle: a new command being accepted and announced, and the transfer of the previous direct-I/O command. The read capture that ends that transfer lands on the same edge where the new command's fields are latched. The bench provokes this by issuing commands at the minimum spacing of two cycles, random mixes and directed pairs alike. In those cycles it also changes the decoded fields, the configuration bits and the I/O read data. A cycle-level model tracks the last two accepted commands. It judges the transfer address, strobes, write byte, captured transmit word and the new announce pattern separately each cycle.

// File: rtl/mcio_pkg.sv
// Package: shared constants and types for the mode command discrete I/O bridge.
// Assumes: command field width follows the serial bus protocol (5 bits).
package mcio_pkg;

    localparam int FIELD_W = 5;   // word count / mode code width
    localparam int BYTE_W  = 8;   // I/O data path width
    localparam int IOA_W   = 2;   // I/O address width

    // kind of transfer a command requests on the I/O bus
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } io_op_e;

    // one pending I/O transfer
    typedef struct packed {
        io_op_e            op;
        logic [IOA_W-1:0]  addr;
        logic [BYTE_W-1:0] wdata;
    } io_req_t;

endpackage

// File: rtl/mcio_decode.sv
// Module: mcio_decode
// Maps a command's fields onto the I/O transfer it requests, if any.
// Only mode commands with the direct-I/O enable set and a matching direction
// produce a transfer. Purely combinational; legality is gated by the caller.
module mcio_decode
    import mcio_pkg::*;
#(
    parameter int MC_RD_A = 24,   // transmit code reading address A
    parameter int MC_RD_B = 25,   // transmit code reading address B
    parameter int MC_WR_B = 27,   // receive code writing address B
    parameter int MC_WR_A = 28,   // receive code writing address A
    parameter int ADDR_A  = 0,
    parameter int ADDR_B  = 2
) (
    input  logic               dio_en,
    input  logic               tx,
    input  logic               mode,
    input  logic [FIELD_W-1:0] field,
    input  logic [BYTE_W-1:0]  wbyte,
    output io_req_t            req
);

    localparam logic [FIELD_W-1:0] C_RD_A = FIELD_W'(MC_RD_A);
    localparam logic [FIELD_W-1:0] C_RD_B = FIELD_W'(MC_RD_B);
    localparam logic [FIELD_W-1:0] C_WR_B = FIELD_W'(MC_WR_B);
    localparam logic [FIELD_W-1:0] C_WR_A = FIELD_W'(MC_WR_A);
    localparam logic [IOA_W-1:0]   A_A    = IOA_W'(ADDR_A);
    localparam logic [IOA_W-1:0]   A_B    = IOA_W'(ADDR_B);

    // select the transfer kind, address and write byte for the command
    always_comb begin
        req.op    = OP_NONE;
        req.addr  = '0;
        req.wdata = '0;
        if (dio_en && mode) begin
            if (tx) begin
                if (field == C_RD_A) begin
                    req.op   = OP_RD;
                    req.addr = A_A;
                end else if (field == C_RD_B) begin
                    req.op   = OP_RD;
                    req.addr = A_B;
                end
            end else begin
                if (field == C_WR_B) begin
                    req.op    = OP_WR;
                    req.addr  = A_B;
                    req.wdata = wbyte;
                end else if (field == C_WR_A) begin
                    req.op    = OP_WR;
                    req.addr  = A_A;
                    req.wdata = wbyte;
                end
            end
        end
    end

endmodule

// File: rtl/mcio_announce.sv
// Module: mcio_announce
// Registers the one-cycle command announcement and its discrete pattern:
// either the echoed command field or a one-hot pulse picked by the select.
// Assumes: load pulses are at least two cycles apart.
module mcio_announce
    import mcio_pkg::*;
#(
    parameter int DSC_W = 5,
    parameter int SEL_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               echo,
    input  logic [FIELD_W-1:0] field,
    input  logic [SEL_W-1:0]   sel,
    output logic               act,
    output logic [DSC_W-1:0]   dsc
);

    logic [DSC_W-1:0] pulse_pat;
    logic [DSC_W-1:0] echo_pat;
    logic             act_q;
    logic             echo_q;
    logic [DSC_W-1:0] dsc_q;

    // one-hot pulse decoder: select values beyond the output width give zero
    for (genvar g = 0; g < DSC_W; g++) begin : g_pulse
        assign pulse_pat[g] = (sel == SEL_W'(g));
    end

    assign echo_pat = DSC_W'(field);

    // capture announce state on each accepted command, clear otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            echo_q <= 1'b0;
            dsc_q  <= '0;
        end else begin
            act_q  <= load;
            echo_q <= echo;
            dsc_q  <= load ? (echo ? echo_pat : pulse_pat) : '0;
        end
    end

    assign act = act_q;
    assign dsc = dsc_q;

    // R2: the announcement never lasts two cycles
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |=> !act_q);

    // R4: pulse mode sets at most one discrete line
    a_r4_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !echo_q) |-> $onehot0(dsc_q));

endmodule

// File: rtl/mcio_xfer.sv
// Module: mcio_xfer
// Two-stage transfer sequencer: a request latched with the command waits one
// cycle, then owns the I/O bus for one cycle. Read data is captured at the
// end of the read cycle and held until the next read.
// Assumes: load pulses are at least two cycles apart.
module mcio_xfer
    import mcio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  io_req_t           req_in,
    input  logic [BYTE_W-1:0] io_rdata,
    output io_req_t           cur,
    output logic [BYTE_W-1:0] rd_byte
);

    io_req_t           pend_q;
    io_req_t           act_q;
    logic [BYTE_W-1:0] rd_q;

    localparam io_req_t REQ_IDLE = '{op: OP_NONE, addr: '0, wdata: '0};

    // advance the request from the waiting stage to the bus stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= REQ_IDLE;
            act_q  <= REQ_IDLE;
        end else begin
            act_q  <= pend_q;
            pend_q <= load ? req_in : REQ_IDLE;
        end
    end

    // capture the byte returned by the bus at the end of a read cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (act_q.op == OP_RD) begin
            rd_q <= io_rdata;
        end
    end

    assign cur     = act_q;
    assign rd_byte = rd_q;

    // R8: the returned byte changes only after a read cycle
    a_r8_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q.op != OP_RD) |=> $stable(rd_q));

    // R6: a transfer owns the bus for exactly one cycle
    a_r6_one_bus_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q.op != OP_NONE) |=> (act_q.op == OP_NONE));

endmodule

// File: rtl/mcio_bridge.sv
// Module: mcio_bridge (top)
// Turns accepted commands into a one-cycle announce on the discrete pins and,
// for the direct-I/O mode codes, a one-cycle byte transfer on the I/O bus the
// cycle after. Merges both onto the shared strobes and address.
// Assumes: cmd_vld pulses are at least two cycles apart; no host state gates
// the direct-I/O codes.
module mcio_bridge
    import mcio_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int DSC_W   = 5,
    parameter int SEL_W   = 3,
    parameter int MC_RD_A = 24,
    parameter int MC_RD_B = 25,
    parameter int MC_WR_B = 27,
    parameter int MC_WR_A = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_vld,
    input  logic               cmd_legal,
    input  logic               cmd_tx,
    input  logic               cmd_mode,
    input  logic [FIELD_W-1:0] cmd_field,
    input  logic [WORD_W-1:0]  rx_word,
    input  logic               cfg_dio_en,
    input  logic               cfg_echo,
    input  logic [SEL_W-1:0]   tag_pulse_sel,
    input  logic [BYTE_W-1:0]  io_rdata,
    output logic [IOA_W-1:0]   io_addr,
    output logic               io_wr_n,
    output logic               io_rd_n,
    output logic               io_cmds,
    output logic [BYTE_W-1:0]  io_wdata,
    output logic [DSC_W-1:0]   dsc_out,
    output logic [WORD_W-1:0]  tx_word
);

    logic              load;
    io_req_t           dec_req;
    io_req_t           cur;
    logic [BYTE_W-1:0] rd_byte;
    logic              ann_act;
    logic [DSC_W-1:0]  ann_dsc;
    logic              xfer_on;
    logic              unused_rx_hi;

    assign load         = cmd_vld && cmd_legal;
    assign unused_rx_hi = ^rx_word[WORD_W-1:BYTE_W];

    mcio_decode #(
        .MC_RD_A (MC_RD_A),
        .MC_RD_B (MC_RD_B),
        .MC_WR_B (MC_WR_B),
        .MC_WR_A (MC_WR_A),
        .ADDR_A  (0),
        .ADDR_B  (2)
    ) u_decode (
        .dio_en (cfg_dio_en),
        .tx     (cmd_tx),
        .mode   (cmd_mode),
        .field  (cmd_field),
        .wbyte  (rx_word[BYTE_W-1:0]),
        .req    (dec_req)
    );

    mcio_announce #(
        .DSC_W (DSC_W),
        .SEL_W (SEL_W)
    ) u_announce (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .echo  (cfg_echo),
        .field (cmd_field),
        .sel   (tag_pulse_sel),
        .act   (ann_act),
        .dsc   (ann_dsc)
    );

    mcio_xfer u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .req_in   (dec_req),
        .io_rdata (io_rdata),
        .cur      (cur),
        .rd_byte  (rd_byte)
    );

    assign xfer_on = (cur.op != OP_NONE);

    // merge announce and transfer onto the shared bus pins
    always_comb begin
        io_cmds  = ann_act;
        dsc_out  = ann_dsc;
        io_addr  = xfer_on ? cur.addr : '0;
        io_wr_n  = !(ann_act || (cur.op == OP_WR));
        io_rd_n  = !(cur.op == OP_RD);
        io_wdata = (cur.op == OP_WR) ? cur.wdata : '0;
        tx_word  = WORD_W'(rd_byte);
    end

    // R2: every announce was caused by an accepted command one cycle earlier
    a_r2_announce_cause: assert property (@(posedge clk) disable iff (!rst_n)
        io_cmds |-> $past(cmd_vld && cmd_legal));

    // R5: discrete lines are quiet outside the announce cycle
    a_r5_discrete_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !io_cmds |-> (dsc_out == '0));

    // R10: announce and transfer never share a cycle
    a_r10_disjoint_phases: assert property (@(posedge clk) disable iff (!rst_n)
        !(ann_act && xfer_on));

    // R6: a read cycle drives neither the write strobe nor the command strobe
    a_r6_read_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd_n |-> (io_wr_n && !io_cmds));

endmodule

// File: tb/sim_mcio_bridge.sv
// Bench: cycle model of the last two accepted commands, random mix + directed.
module sim_mcio_bridge;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_vld, cmd_legal, cmd_tx, cmd_mode;
    logic [4:0]  cmd_field;
    logic [15:0] rx_word;
    logic        cfg_dio_en, cfg_echo;
    logic [2:0]  tag_pulse_sel;
    logic [7:0]  io_rdata;
    logic [1:0]  io_addr;
    logic        io_wr_n, io_rd_n, io_cmds;
    logic [7:0]  io_wdata;
    logic [4:0]  dsc_out;
    logic [15:0] tx_word;

    always #5 clk = ~clk;

    mcio_bridge u0 (.*);

    // bench I/O device: two readable bytes
    logic [7:0] reg_a, reg_b;
    assign io_rdata = (io_addr == 2'd2) ? reg_b : reg_a;

    typedef struct packed {
        logic        vld, legal, tx, mode;
        logic [4:0]  f;
        logic [15:0] rx;
        logic        dio, echo;
        logic [2:0]  sel;
    } bcmd_t;

    localparam bcmd_t IDLE = '0;

    bcmd_t       h1, h2;
    logic [15:0] exp_tx;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic is_dio(bcmd_t c);
        if (!(c.vld && c.legal && c.dio && c.mode)) return 1'b0;
        return c.tx ? (c.f == 5'd24 || c.f == 5'd25) : (c.f == 5'd27 || c.f == 5'd28);
    endfunction

    function automatic logic [4:0] exp_dsc(bcmd_t c);
        if (!(c.vld && c.legal)) return 5'd0;
        if (c.echo) return c.f;
        return (c.sel < 3'd5) ? 5'(1 << c.sel) : 5'd0;
    endfunction

    function automatic bcmd_t mk(logic legal, logic tx, logic mode, logic [4:0] f,
                                 logic [15:0] rx, logic dio, logic echo, logic [2:0] sel);
        bcmd_t c;
        c.vld = 1'b1; c.legal = legal; c.tx = tx; c.mode = mode; c.f = f;
        c.rx = rx; c.dio = dio; c.echo = echo; c.sel = sel;
        return c;
    endfunction

    task automatic apply(bcmd_t c);
        cmd_vld = c.vld; cmd_legal = c.legal; cmd_tx = c.tx; cmd_mode = c.mode;
        cmd_field = c.f; rx_word = c.rx; cfg_dio_en = c.dio; cfg_echo = c.echo;
        tag_pulse_sel = c.sel;
    endtask

    // one cycle: check outputs from the model, then drive the next command
    task automatic step(bcmd_t d);
        logic ann, d2, rd2, wr2, other;
        logic [1:0] eaddr;
        string t_io, t_ds;
        @(negedge clk);
        ann   = h1.vld && h1.legal;
        d2    = is_dio(h2);
        rd2   = d2 && h2.tx;
        wr2   = d2 && !h2.tx;
        other = h2.vld && h2.legal && !d2;
        eaddr = (d2 && (h2.f == 5'd25 || h2.f == 5'd27)) ? 2'd2 : 2'd0;
        if (d2 && h1.vld)  t_io = "R10";
        else if (other)    t_io = "R9";
        else               t_io = "R6";
        if (!ann)          t_ds = "R5";
        else if (h1.echo)  t_ds = "R3";
        else               t_ds = "R4";
        chk("R2", "io_cmds", 16'(io_cmds), 16'(ann));
        chk(t_ds, "dsc_out", 16'(dsc_out), 16'(exp_dsc(h1)));
        chk(t_io, "io_addr", 16'(io_addr), 16'(eaddr));
        chk(t_io, "io_rd_n", 16'(io_rd_n), 16'(!rd2));
        chk(ann ? "R2" : t_io, "io_wr_n", 16'(io_wr_n), 16'(!(ann || wr2)));
        chk("R7", "io_wdata", 16'(io_wdata), wr2 ? 16'(h2.rx[7:0]) : 16'd0);
        chk((d2 && h1.vld) ? "R10" : "R8", "tx_word", tx_word, exp_tx);
        // device contents may change while a read is under way (R10 stress)
        if ($urandom_range(3) == 0) reg_a = 8'($urandom);
        if ($urandom_range(3) == 0) reg_b = 8'($urandom);
        apply(d);
        if (rd2) exp_tx = {8'h00, (h2.f == 5'd25) ? reg_b : reg_a};
        h2 = h1;
        h1 = d;
    endtask

    task automatic run_one(bcmd_t c);
        step(c);
        step(IDLE);
        step(IDLE);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1553);
        reg_a = 8'h5A; reg_b = 8'hC3;
        h1 = IDLE; h2 = IDLE; exp_tx = 16'd0;
        apply(IDLE);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1: idle outputs while reset is held
        repeat (2) begin
            @(negedge clk);
            chk("R1", "io_cmds", 16'(io_cmds), 16'd0);
            chk("R1", "io_wr_n", 16'(io_wr_n), 16'd1);
            chk("R1", "io_rd_n", 16'(io_rd_n), 16'd1);
            chk("R1", "io_addr", 16'(io_addr), 16'd0);
            chk("R1", "io_wdata", 16'(io_wdata), 16'd0);
            chk("R1", "dsc_out", 16'(dsc_out), 16'd0);
            chk("R1", "tx_word", tx_word, 16'd0);
        end
        rst_n = 1'b1;
        step(IDLE);
        step(IDLE);

        // R6 R8: the four direct-I/O codes, R3 echo and R4 pulse
        run_one(mk(1, 1, 1, 5'd24, 16'hFFFF, 1, 1, 3'd0));
        run_one(mk(1, 1, 1, 5'd25, 16'h0000, 1, 0, 3'd2));
        run_one(mk(1, 0, 1, 5'd27, 16'hA55A, 1, 0, 3'd4)); // R7 high byte ignored
        run_one(mk(1, 0, 1, 5'd28, 16'h3CC3, 1, 0, 3'd7)); // R4 select out of range
        // R9: no transfer when disabled, wrong direction, not a mode code, other code
        run_one(mk(1, 1, 1, 5'd24, 16'h1111, 0, 1, 3'd1));
        run_one(mk(1, 1, 1, 5'd27, 16'h2222, 1, 1, 3'd1));
        run_one(mk(1, 0, 1, 5'd25, 16'h3333, 1, 0, 3'd3));
        run_one(mk(1, 1, 0, 5'd25, 16'h4444, 1, 0, 3'd1));
        run_one(mk(1, 1, 1, 5'd26, 16'h5555, 1, 1, 3'd0));
        // R2: an illegal command produces nothing
        run_one(mk(0, 1, 1, 5'd24, 16'h6666, 1, 1, 3'd0));
        run_one(mk(0, 0, 1, 5'd28, 16'h7777, 1, 0, 3'd0));
        // R10: next command accepted in the transfer cycle of the previous one
        step(mk(1, 1, 1, 5'd25, 16'h0000, 1, 0, 3'd1));
        step(IDLE);
        step(mk(1, 0, 1, 5'd28, 16'hBE12, 1, 1, 3'd0));
        step(IDLE);
        step(mk(1, 1, 1, 5'd24, 16'h0000, 1, 0, 3'd3));
        step(IDLE);
        step(mk(1, 0, 1, 5'd27, 16'h9981, 1, 0, 3'd6));
        step(IDLE);
        step(IDLE);

        // constrained random mix at spacing two or more
        for (int i = 0; i < 3000; i++) begin
            bcmd_t c;
            if (h1.vld || $urandom_range(9) < 4) begin
                c = IDLE;
                c.f = 5'($urandom);  // garbage on fields without a strobe
                c.rx = 16'($urandom);
                c.dio = 1'($urandom);
            end else begin
                logic [4:0] codes [5];
                codes = '{5'd24, 5'd25, 5'd26, 5'd27, 5'd28};
                c = mk(($urandom_range(7) != 0), 1'($urandom),
                       ($urandom_range(3) != 0),
                       ($urandom_range(1) == 0) ? codes[$urandom_range(4)] : 5'($urandom),
                       16'($urandom), ($urandom_range(3) != 0), 1'($urandom),
                       3'($urandom));
            end
            step(c);
        end
        step(IDLE);
        step(IDLE);
        step(IDLE);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule